// File: doc/BRIEF.md
# Pipeline hazard and bypass controller

This block holds the hazard-control decisions for a five-stage in-order integer pipeline. It watches the source registers of the instruction sitting in decode and compares them with the destination registers of the instructions in the execute and memory stages. From these comparisons it produces three things: an interlock that freezes the front of the pipe, a cancel for the one sequentially fetched instruction after a taken branch, and select codes for the operand bypass multiplexers in front of the ALU.

Every decision is made while the consuming instruction is in decode. The ALU operand selects are registered into a decode/execute slice, so they travel with the instruction. Branches compare and compute their target in decode, and fetch assumes the branch is not taken. The register file writes in the first half of a cycle and reads in the second half, so the controller takes no action for a producer that is already in writeback, and writeback is not an input.

Top module: `hz_ctrl`

## Requirements
- R1: A load in execute (ex_wr=1, ex_load=1, ex_rd nonzero) whose ex_rd equals a used decode source raises pc_hold, fd_hold and de_bubble together in that same cycle.
- R2: An ALU producer in execute (ex_wr=1, ex_load=0) that matches a used decode source causes no stall, and at the next clock that operand's ex_sel becomes 1 (take the execute/memory register).
- R3: A producer in memory (mem_wr=1, load or ALU) that matches a used source and has no match in execute causes no stall for a non-branch, and at the next clock ex_sel becomes 2 (take the memory/writeback register). A memory entry with mem_wr=0 never matches.
- R4: With no match in execute or memory, the controller raises no hold, no cancel and no bypass, and ex_sel becomes 0 (register file).
- R5: Register 0 never matches, whatever the destination fields and write flags hold.
- R6: When execute and memory both write the matching register, ex_sel picks the younger one, code 1.
- R7: ex_sel_a and ex_sel_b are 0 after reset, and they are 0 in the cycle after any stall, because a bubble enters execute.
- R8: A branch in decode with id_br_taken=1 and no stall raises fd_kill and pc_redirect. With id_br_taken=0 it raises neither.
- R9: While a stall is raised, fd_kill and pc_redirect stay low.
- R10: A branch stalls when a used source matches any producer in execute (ALU or load), or a load in memory. A load ahead of a branch therefore costs two stall cycles.
- R11: A branch whose used source matches an ALU producer in memory, with no execute match, does not stall on that operand and raises br_byp for it.
- R12: A source whose use flag is 0 creates no stall and no bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs_a | input | AW | First source register of the decode instruction |
| id_rs_b | input | AW | Second source register of the decode instruction |
| id_use_a | input | 1 | Decode instruction reads id_rs_a |
| id_use_b | input | 1 | Decode instruction reads id_rs_b |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Branch compare result from decode |
| ex_rd | input | AW | Destination register of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination register of the memory instruction |
| mem_wr | input | 1 | Memory instruction writes a register |
| mem_load | input | 1 | Memory instruction is a load |
| pc_hold | output | 1 | Keep the program counter |
| fd_hold | output | 1 | Keep the fetch/decode register |
| de_bubble | output | 1 | Load a no-op into the decode/execute register |
| fd_kill | output | 1 | Turn the wrong-path fetch into a bubble |
| pc_redirect | output | 1 | Steer fetch to the branch target |
| br_byp_a | output | 1 | Branch compare operand A taken from the execute/memory register |
| br_byp_b | output | 1 | Branch compare operand B taken from the execute/memory register |
| ex_sel_a | output | 2 | Registered ALU operand A select: 0 register file, 1 execute/memory, 2 memory/writeback |
| ex_sel_b | output | 2 | Registered ALU operand B select, same coding |

## Verification
The checker watches the timing links on every cycle. A load-use match must raise the hold in the same cycle. A stall must leave zero selects behind it. A stall must block the branch cancel, and a taken branch with no stall must redirect. A register 0 source or a source that is not read must never leave a bypass code. It also checks that a younger ALU match selects code 1 and that a branch bypass only appears against an ALU producer in memory. The bench scenarios are the only place that shows the full code chosen for memory-stage producers, the branch stall against a load in memory, and the clearing of the selects by reset.

// File: rtl/hz_pkg.sv
// Package: shared constants and the bypass select coding for the hazard
// controller. Assumes two source operands per instruction.
package hz_pkg;
    localparam int NUM_SRC = 2;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_RF    = 2'd0,
        SEL_EXMEM = 2'd1,
        SEL_MEMWB = 2'd2
    } byp_sel_e;
endpackage

// File: rtl/hz_src_cmp.sv
// Module: compares one decode source against the execute and memory
// destinations. Assumes register 0 is constant zero, so it never matches.
// The younger producer (execute) wins the bypass select.
module hz_src_cmp
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic          use_src,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wr,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wr,
    input  logic          mem_load,
    output logic          hit_ex,
    output logic          ld_ex,
    output logic          ld_mem,
    output logic          br_fwd,
    output logic [SEL_W-1:0] sel
);
    logic live;
    logic hit_mem;

    // Match the source against both producer stages.
    always_comb begin
        live    = use_src && (src != '0);
        hit_ex  = live && ex_wr  && (ex_rd  == src);
        hit_mem = live && mem_wr && (mem_rd == src);
        ld_ex   = hit_ex  && ex_load;
        ld_mem  = hit_mem && mem_load;
        br_fwd  = hit_mem && !mem_load && !hit_ex;
    end

    // Choose the bypass source, with the youngest producer first.
    always_comb begin
        if (hit_ex)       sel = SEL_EXMEM;
        else if (hit_mem) sel = SEL_MEMWB;
        else              sel = SEL_RF;
    end
endmodule

// File: rtl/hz_stall_unit.sv
// Module: combines the per-source matches into an interlock and the
// branch-not-taken recovery. Assumes branches resolve in decode and that
// a stall outranks a flush.
module hz_stall_unit
    import hz_pkg::*;
(
    input  logic               id_branch,
    input  logic               id_br_taken,
    input  logic [NUM_SRC-1:0] hit_ex,
    input  logic [NUM_SRC-1:0] ld_ex,
    input  logic [NUM_SRC-1:0] ld_mem,
    output logic               stall,
    output logic               flush
);
    // Load-use always interlocks; a branch also waits on execute ALU or memory load results.
    always_comb begin
        stall = (|ld_ex) || (id_branch && ((|hit_ex) || (|ld_mem)));
        flush = id_branch && id_br_taken && !stall;
    end
endmodule

// File: rtl/hz_sel_reg.sv
// Module: decode/execute slice that carries the operand bypass selects
// with the instruction. A bubble or reset loads the register-file code.
module hz_sel_reg
    import hz_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bubble,
    input  logic [NUM_SRC-1:0][SEL_W-1:0] sel_d,
    output logic [NUM_SRC-1:0][SEL_W-1:0] sel_q
);
    // Register the selects, and clear them on reset or a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n || bubble) sel_q <= '0;
        else                  sel_q <= sel_d;
    end
endmodule

// File: rtl/hz_ctrl.sv
// Module: top of the hazard and bypass controller. Assumes a five-stage
// in-order pipe, a register file that writes before it reads, and
// predict-not-taken fetch with branches resolved in decode.
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs_a,
    input  logic [AW-1:0] id_rs_b,
    input  logic          id_use_a,
    input  logic          id_use_b,
    input  logic          id_branch,
    input  logic          id_br_taken,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wr,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wr,
    input  logic          mem_load,
    output logic          pc_hold,
    output logic          fd_hold,
    output logic          de_bubble,
    output logic          fd_kill,
    output logic          pc_redirect,
    output logic          br_byp_a,
    output logic          br_byp_b,
    output logic [1:0]    ex_sel_a,
    output logic [1:0]    ex_sel_b
);
    logic [NUM_SRC-1:0][AW-1:0]    src;
    logic [NUM_SRC-1:0]            use_v;
    logic [NUM_SRC-1:0]            hit_ex;
    logic [NUM_SRC-1:0]            ld_ex;
    logic [NUM_SRC-1:0]            ld_mem;
    logic [NUM_SRC-1:0]            br_fwd;
    logic [NUM_SRC-1:0][SEL_W-1:0] sel_d;
    logic [NUM_SRC-1:0][SEL_W-1:0] sel_q;
    logic                          stall;
    logic                          flush;

    // Gather the decode sources into an array.
    always_comb begin
        src[0]   = id_rs_a;
        src[1]   = id_rs_b;
        use_v[0] = id_use_a;
        use_v[1] = id_use_b;
    end

    // One comparator per source operand.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hz_src_cmp #(.AW(AW)) u_cmp (
            .src      (src[g]),
            .use_src  (use_v[g]),
            .ex_rd    (ex_rd),
            .ex_wr    (ex_wr),
            .ex_load  (ex_load),
            .mem_rd   (mem_rd),
            .mem_wr   (mem_wr),
            .mem_load (mem_load),
            .hit_ex   (hit_ex[g]),
            .ld_ex    (ld_ex[g]),
            .ld_mem   (ld_mem[g]),
            .br_fwd   (br_fwd[g]),
            .sel      (sel_d[g])
        );
    end

    hz_stall_unit u_stall (
        .id_branch   (id_branch),
        .id_br_taken (id_br_taken),
        .hit_ex      (hit_ex),
        .ld_ex       (ld_ex),
        .ld_mem      (ld_mem),
        .stall       (stall),
        .flush       (flush)
    );

    hz_sel_reg u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .bubble (stall),
        .sel_d  (sel_d),
        .sel_q  (sel_q)
    );

    // Drive the pipeline control outputs.
    always_comb begin
        pc_hold     = stall;
        fd_hold     = stall;
        de_bubble   = stall;
        fd_kill     = flush;
        pc_redirect = flush;
        br_byp_a    = id_branch && br_fwd[0];
        br_byp_b    = id_branch && br_fwd[1];
        ex_sel_a    = sel_q[0];
        ex_sel_b    = sel_q[1];
    end
endmodule

// File: rtl/hz_ctrl_chk.sv
// Module: property checker for hz_ctrl, attached with bind. It observes
// only the ports of the controller.
module hz_ctrl_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] id_rs_a,
    input logic          id_use_a,
    input logic          id_branch,
    input logic          id_br_taken,
    input logic [AW-1:0] ex_rd,
    input logic          ex_wr,
    input logic          ex_load,
    input logic [AW-1:0] mem_rd,
    input logic          mem_wr,
    input logic          mem_load,
    input logic          pc_hold,
    input logic          fd_kill,
    input logic          pc_redirect,
    input logic          br_byp_a,
    input logic [1:0]    ex_sel_a,
    input logic [1:0]    ex_sel_b
);
    logic a_ex_match;
    always_comb a_ex_match = id_use_a && (id_rs_a != '0) && ex_wr && (ex_rd == id_rs_a);

    assert_load_use_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ex_match && ex_load) |-> pc_hold);

    assert_young_alu_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ex_match && !ex_load && !pc_hold) |=> (ex_sel_a == 2'd1));

    assert_zero_reg_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((id_rs_a == '0) && !pc_hold) |=> (ex_sel_a == 2'd0));

    assert_bubble_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> (ex_sel_a == 2'd0 && ex_sel_b == 2'd0));

    assert_taken_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (id_branch && id_br_taken && !pc_hold) |-> (fd_kill && pc_redirect));

    assert_stall_blocks_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (!fd_kill && !pc_redirect));

    assert_branch_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (id_branch && a_ex_match) |-> pc_hold);

    assert_branch_bypass_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        br_byp_a |-> (mem_wr && !mem_load && (mem_rd == id_rs_a) && (mem_rd != '0)));

    assert_unused_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_use_a && !pc_hold) |=> (ex_sel_a == 2'd0));
endmodule

bind hz_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/hz_ctrl_bench.sv
// Bench: walks a vector table through hz_ctrl, then runs directed reset checks.
module hz_ctrl_bench;
    localparam int AW = 5;
    localparam int NV = 13;
    localparam int VW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] id_rs_a = '0, id_rs_b = '0, ex_rd = '0, mem_rd = '0;
    logic id_use_a = 0, id_use_b = 0, id_branch = 0, id_br_taken = 0;
    logic ex_wr = 0, ex_load = 0, mem_wr = 0, mem_load = 0;
    logic pc_hold, fd_hold, de_bubble, fd_kill, pc_redirect, br_byp_a, br_byp_b;
    logic [1:0] ex_sel_a, ex_sel_b;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    hz_ctrl #(.AW(AW)) u_hz_ctrl (.*);

    // Fields: rs_a rs_b use_a use_b br taken | ex_rd ex_wr ex_ld | mem_rd mem_wr mem_ld
    //         | stall kill byp_a byp_b sel_a sel_b
    localparam logic [VW-1:0] VEC [NV] = '{
        {5'd1,5'd2,1'b1,1'b1,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd4,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0},
        {5'd1,5'd2,1'b1,1'b1,1'b0,1'b0, 5'd1,1'b1,1'b0, 5'd4,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd1,2'd0},
        {5'd1,5'd2,1'b1,1'b1,1'b0,1'b0, 5'd2,1'b1,1'b1, 5'd4,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0,2'd0,2'd0},
        {5'd1,5'd2,1'b1,1'b1,1'b0,1'b0, 5'd5,1'b1,1'b0, 5'd1,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,2'd2,2'd0},
        {5'd3,5'd3,1'b1,1'b1,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd3,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,2'd1,2'd1},
        {5'd0,5'd0,1'b1,1'b1,1'b0,1'b0, 5'd0,1'b1,1'b1, 5'd0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0},
        {5'd6,5'd7,1'b0,1'b0,1'b0,1'b0, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0},
        {5'd8,5'd9,1'b1,1'b1,1'b1,1'b1, 5'd3,1'b1,1'b0, 5'd4,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0,2'd0,2'd0},
        {5'd8,5'd9,1'b1,1'b1,1'b1,1'b0, 5'd3,1'b1,1'b0, 5'd4,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0},
        {5'd8,5'd9,1'b1,1'b1,1'b1,1'b1, 5'd8,1'b1,1'b0, 5'd4,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0,2'd0,2'd0},
        {5'd8,5'd9,1'b1,1'b1,1'b1,1'b0, 5'd3,1'b1,1'b0, 5'd9,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,2'd0,2'd0},
        {5'd8,5'd9,1'b1,1'b1,1'b1,1'b1, 5'd3,1'b1,1'b0, 5'd9,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b1,2'd0,2'd2},
        {5'd1,5'd2,1'b1,1'b1,1'b0,1'b0, 5'd5,1'b1,1'b0, 5'd1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0,2'd0}
    };
    string tags [NV] = '{"R4", "R2", "R1", "R3", "R6", "R5", "R12",
                         "R8", "R8", "R10", "R10", "R11", "R3"};

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [VW-1:0] v);
        id_rs_a = v[35:31]; id_rs_b = v[30:26];
        id_use_a = v[25]; id_use_b = v[24]; id_branch = v[23]; id_br_taken = v[22];
        ex_rd = v[21:17]; ex_wr = v[16]; ex_load = v[15];
        mem_rd = v[14:10]; mem_wr = v[9]; mem_load = v[8];
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R7: reset clears the selects even with a forwarding pattern present.
        @(negedge clk);
        drive(VEC[1]);
        @(posedge clk); #2;
        check("R7", "reset sel_a", ex_sel_a, 0);
        check("R7", "reset sel_b", ex_sel_b, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #2;
            check(tags[i], "pc_hold", pc_hold, VEC[i][7]);
            check(tags[i], "fd_hold", fd_hold, VEC[i][7]);
            check(tags[i], "de_bubble", de_bubble, VEC[i][7]);
            check(tags[i], "fd_kill", fd_kill, VEC[i][6]);
            check(tags[i], "pc_redirect", pc_redirect, VEC[i][6]);
            check(tags[i], "br_byp_a", br_byp_a, VEC[i][5]);
            check(tags[i], "br_byp_b", br_byp_b, VEC[i][4]);
            @(posedge clk); #2;
            check(tags[i], "ex_sel_a", ex_sel_a, VEC[i][3:2]);
            check(tags[i], "ex_sel_b", ex_sel_b, VEC[i][1:0]);
        end

        // R7: a stall after a forwarding cycle leaves a bubble with zero selects.
        @(negedge clk);
        drive(VEC[4]);
        @(posedge clk); #2;
        check("R6", "sel_a before stall", ex_sel_a, 1);
        @(negedge clk);
        drive(VEC[2]);
        @(posedge clk); #2;
        check("R7", "bubble sel_a", ex_sel_a, 0);
        check("R7", "bubble sel_b", ex_sel_b, 0);

        // R7: a mid-run reset clears live selects.
        @(negedge clk);
        drive(VEC[4]);
        rst_n = 1'b0;
        @(posedge clk); #2;
        check("R7", "mid reset sel_a", ex_sel_a, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R6", "after reset sel_b", ex_sel_b, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule